// File: doc/BRIEF.md
# Bit-Serial Register File with Offset Read

This block is the operand store of a bit-serial datapath. It keeps eight 8-bit registers. Two read ports each return one bit per cycle, and the bit they return is picked by a bit index that an outside counter steps once per clock. The first read port also returns the whole selected register at once, which load operations use. The single write port replaces a whole register in one clock edge, taking its value from the accumulator.

For logical shift instructions the first serial port does not read at the running index. It reads at the index moved by a 3-bit shift amount. The bit stream that reaches the ALU is therefore already shifted, and positions outside the register read as zero. The stored data is never moved. The second serial port always reads at the running index, because only register-register instructions use it.

All reads are combinational from the stored registers, so a read in the same cycle as a write to the same register sees the old contents. None of the pins carries a stream, so there is no valid/ready handshake. Every read is ready in the cycle it is asked for, and a write is taken on every edge where it is enabled, so nothing can stall. Reset is synchronous and active low.

Top module: `serial_regfile`

## Requirements
- R1: On a clock edge with `rst_n` low, all eight registers become zero. After reset every address reads 0x00 on `rd1_word` and 0 on both serial ports.
- R2: When `wr_en` is high at a rising edge, the register at `wr_addr` takes all 8 bits of `wr_data`. The new value is seen on `rd1_word` from the next cycle.
- R3: When `wr_en` is low at a rising edge, no register changes, whatever `wr_addr` and `wr_data` hold.
- R4: A read of a register that is being written in the same cycle returns the value from before the write.
- R5: With `shift_en` low, `rd1_bit` equals bit `bit_idx` (bit 0 is the LSB) of the register at `rd1_addr`.
- R6: `rd2_bit` equals bit `bit_idx` of the register at `rd2_addr`. `shift_en`, `shift_right` and `shamt` do not affect it.
- R7: With `shift_en` high and `shift_right` low (left shift by s = `shamt`), `rd1_bit` is register bit `bit_idx - s`. It is 0 when `bit_idx < s`.
- R8: With `shift_en` high and `shift_right` high (right shift by s), `rd1_bit` is register bit `bit_idx + s`. It is 0 when `bit_idx + s > 7`.
- R9: `rd1_word` always shows the unshifted register at `rd1_addr`, whatever the shift controls hold.
- R10: A write changes only the register at `wr_addr`. The other seven keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd1_addr | input | 3 | Register selected for the first read port |
| rd2_addr | input | 3 | Register selected for the second read port |
| bit_idx | input | 3 | Running bit position, 0 = LSB |
| shamt | input | 3 | Shift amount applied to the first serial port |
| shift_right | input | 1 | 1 = right shift, 0 = left shift |
| shift_en | input | 1 | Enables the shift offset on the first serial port |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 3 | Register to write |
| wr_data | input | 8 | Value written (from the accumulator) |
| rd1_bit | output | 1 | Serial bit of the first port, offset when shifting |
| rd2_bit | output | 1 | Serial bit of the second port |
| rd1_word | output | 8 | Whole register at `rd1_addr`, unshifted |

## Verification
On every cycle the assertions check these things: the clean state after reset, that an enabled write lands in full, that an idle edge or a write elsewhere leaves each register unchanged, that the out-of-range shift positions read zero, and that the unshifted serial bit agrees with the parallel word. The read-before-write result for a register being written in the same cycle needs the bench's scenarios and its model. So do the exact source bit chosen for every shift amount and direction, and the independence of the second port from the shift controls.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;

  typedef struct packed {
    logic       en;
    shift_dir_e dir;
  } shift_ctl_t;

endpackage

// File: rtl/rfs_store.sv
module rfs_store #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

  // One flop bank per entry, each with its own decoded load enable.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_o[g] <= '0;
      end else if (hit) begin
        regs_o[g] <= wr_data;
      end
    end

    AST_OTHERS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_addr != ADDR_W'(g)) |=> $stable(regs_o[g])); // R10
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs_o[$past(wr_addr)] == $past(wr_data)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_o)); // R3

endmodule

// File: rtl/rfs_bit_port.sv
module rfs_bit_port
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(DATA_W)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [IDX_W-1:0]                 shamt_i,
  input  shift_ctl_t                       shift_i,
  output logic                             bit_o
);

  localparam logic [IDX_W:0] TOP_POS = (IDX_W+1)'(DATA_W - 1);

  logic [DATA_W-1:0] word;
  logic [IDX_W:0]    back_pos;   // index minus shift, MSB flags underflow
  logic [IDX_W:0]    fwd_pos;    // index plus shift, may pass the top
  logic [IDX_W-1:0]  src_idx;
  logic              in_range;

  assign word     = regs_i[addr_i];
  assign back_pos = {1'b0, idx_i} - {1'b0, shamt_i};
  assign fwd_pos  = {1'b0, idx_i} + {1'b0, shamt_i};

  always_comb begin
    src_idx  = idx_i;
    in_range = 1'b1;
    if (shift_i.en) begin
      if (shift_i.dir == DIR_LEFT) begin
        src_idx  = back_pos[IDX_W-1:0];
        in_range = !back_pos[IDX_W];
      end else begin
        src_idx  = fwd_pos[IDX_W-1:0];
        in_range = (fwd_pos <= TOP_POS);
      end
    end
  end

  assign bit_o = in_range && word[src_idx];

  AST_LEFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i.en && shift_i.dir == DIR_LEFT && idx_i < shamt_i) |-> !bit_o); // R7

  AST_RIGHT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i.en && shift_i.dir == DIR_RIGHT &&
     (32'(idx_i) + 32'(shamt_i)) >= DATA_W) |-> !bit_o); // R8

endmodule

// File: rtl/rfs_word_port.sv
module rfs_word_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs_i,
  input  logic [ADDR_W-1:0]                addr_i,
  output logic [DATA_W-1:0]                word_o
);

  assign word_o = regs_i[addr_i];

endmodule

// File: rtl/serial_regfile.sv
module serial_regfile
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int IDX_W   = $clog2(DATA_W),
  localparam int N_SER   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  rd1_addr,
  input  logic [ADDR_W-1:0]  rd2_addr,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic [IDX_W-1:0]   shamt,
  input  logic               shift_right,
  input  logic               shift_en,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               rd1_bit,
  output logic               rd2_bit,
  output logic [DATA_W-1:0]  rd1_word
);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [N_SER-1:0]                ser_bits;
  shift_ctl_t                      rd1_shift;

  assign rd1_shift.en  = shift_en;
  assign rd1_shift.dir = shift_dir_e'(shift_right);

  rfs_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  // Port 0 carries the shift offset; port 1 always reads in place.
  for (genvar g = 0; g < N_SER; g++) begin : g_ser
    rfs_bit_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) port_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .regs_i  (regs),
      .addr_i  ((g == 0) ? rd1_addr : rd2_addr),
      .idx_i   (bit_idx),
      .shamt_i (shamt),
      .shift_i ((g == 0) ? rd1_shift : shift_ctl_t'('0)),
      .bit_o   (ser_bits[g])
    );
  end

  rfs_word_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) word_i (
    .regs_i (regs),
    .addr_i (rd1_addr),
    .word_o (rd1_word)
  );

  assign rd1_bit = ser_bits[0];
  assign rd2_bit = ser_bits[1];

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd1_word == '0 && !rd2_bit)); // R1

  AST_PLAIN_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |-> rd1_bit == rd1_word[bit_idx]); // R5

endmodule

// File: tb/serial_regfile_tb.sv
module serial_regfile_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rd1_addr = '0, rd2_addr = '0, bit_idx = '0, shamt = '0, wr_addr = '0;
  logic       shift_right = 1'b0, shift_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd1_bit, rd2_bit;
  logic [7:0] rd1_word;

  int unsigned model [8];
  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .rd1_addr(rd1_addr), .rd2_addr(rd2_addr),
    .bit_idx(bit_idx), .shamt(shamt), .shift_right(shift_right),
    .shift_en(shift_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd1_bit(rd1_bit), .rd2_bit(rd2_bit), .rd1_word(rd1_word)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_bit1(input int a, input int i, input int s,
                                  input bit en, input bit right);
    int src;
    if (!en) src = i;
    else if (right) src = i + s;
    else src = i - s;
    if (src < 0 || src > 7) return 0;
    return (model[a] >> src) & 1;
  endfunction

  // Drive at the falling edge, compare after settling, update model at the rising edge.
  task automatic step(input bit rst, input int a1, input int a2, input int idx,
                      input int sh, input bit en, input bit right,
                      input bit we, input int wa, input int wd,
                      input bit check, input string wtag = "");
    string t_word, t_bit;
    rst_n = rst; rd1_addr = 3'(a1); rd2_addr = 3'(a2); bit_idx = 3'(idx);
    shamt = 3'(sh); shift_en = en; shift_right = right;
    wr_en = we; wr_addr = 3'(wa); wr_data = 8'(wd);
    #1;
    if (check && rst) begin
      if (wtag != "") t_word = wtag;
      else if (we && wa == a1) t_word = "R4";
      else if (en) t_word = "R9";
      else t_word = "R2";
      chk(t_word, int'(rd1_word), int'(model[a1]));
      t_bit = !en ? "R5" : (right ? "R8" : "R7");
      chk(t_bit, int'(rd1_bit), exp_bit1(a1, idx, sh, en, right));
      chk("R6", int'(rd2_bit), int'((model[a2] >> idx) & 1));
    end
    @(posedge clk);
    if (!rst) foreach (model[k]) model[k] = 0;
    else if (we) model[wa] = wd & 8'hFF;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1, 3, 8'h55, 0);
    // R1: every address reads zero after reset
    for (int a = 0; a < 8; a++) step(1, a, 7 - a, a, 0, 0, 0, 0, 0, 0, 1, "R1");

    // R2/R4: write values while reading the same register (old value expected)
    step(1, 3, 0, 0, 0, 0, 0, 1, 3, 8'h73, 1);
    step(1, 4, 3, 1, 0, 0, 0, 1, 4, 8'h2D, 1);
    step(1, 6, 4, 2, 0, 0, 0, 1, 6, 8'h12, 1);
    step(1, 0, 6, 3, 0, 0, 0, 1, 0, 8'hA5, 1);
    step(1, 7, 0, 4, 0, 0, 0, 1, 7, 8'hFF, 1);
    step(1, 3, 3, 5, 0, 0, 0, 1, 3, 8'h8E, 1);  // R4 overwrite, old 0x73 seen

    // R10: sweep all registers after the writes
    for (int a = 0; a < 8; a++) step(1, a, a, 6, 0, 0, 0, 0, 0, 0, 1, "R10");

    // R3: idle edge with junk on write data must not disturb register 2 or 6
    step(1, 1, 1, 0, 0, 0, 0, 0, 2, 8'hFF, 1);
    step(1, 2, 6, 0, 0, 0, 0, 0, 6, 8'hC3, 1, "R3");
    step(1, 6, 2, 0, 0, 0, 0, 0, 0, 0, 1, "R3");

    // R7: left shift of 0x12 by 2 streams 0x48
    for (int i = 0; i < 8; i++) step(1, 6, 4, i, 2, 1, 0, 0, 0, 0, 1);
    // R7/R8: every amount both directions on 0xFF and 0xA5
    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 8; i++) begin
        step(1, 7, 0, i, s, 1, 0, 0, 0, 0, 1);
        step(1, 0, 7, i, s, 1, 1, 0, 0, 0, 1);
      end

    // Mixed traffic
    for (int n = 0; n < 3000; n++) begin
      bit r = ($urandom_range(0, 99) != 0);
      step(r, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 7), $urandom_range(0, 255), r);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule